// File: doc/BRIEF.md
# Product Term Steering Allocator

The allocator takes the general product terms of one logic block and turns them into one OR-sum per macrocell. Every macrocell has its own routing mask over the whole term pool. A macrocell's sum is the OR of the terms its mask enables. Because each mask is independent, any number of terms from zero up to the limit can be steered to any macrocell. A single term may also appear in the masks of several macrocells, so it can be shared among them.

The masks are loaded through a narrow address/data write port. Each write replaces one slice of one macrocell's mask. The sum path is a fixed AND-OR plane that runs from the term inputs straight to the outputs with no register in between. Its depth is the same for every configuration.

The block also checks the loaded configuration against two rules. A macrocell may not hold more than the allowed number of terms. A term may be shared only among macrocells that belong to the same group of four. A breach of either rule raises a flag. The sums are still produced as configured.

Top module: `pta_top`

## Requirements
- R1: While reset is active, and after it, every routing mask is cleared, so `sum_out` is all zero for any `pt_in` and both error flags are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into one 16-term slice of one macrocell's mask. `cfg_addr[6:3]` selects the macrocell. `cfg_addr[2:0]` selects the slice k, which covers terms 16k to 16k+15. Data bit i enables term 16k+i.
- R3: `sum_out[m]` is the OR of the `pt_in` bits enabled in macrocell m's mask. It follows `pt_in` in the same cycle, with no clock edge in the path.
- R4: A macrocell with no enabled term drives a constant 0 on its `sum_out` bit, whatever `pt_in` is.
- R5: `err_count` is high exactly when at least one macrocell has 17 or more enabled terms. A macrocell holding exactly 16 terms does not raise it.
- R6: `err_share` is high exactly when some term is enabled in macrocells from two or more different groups, where macrocell m belongs to group m/4. Sharing a term among the macrocells of a single group does not raise it.
- R7: A write whose slice index is 5, 6 or 7 changes no mask. `sum_out` and both flags stay as they were.
- R8: A written slice takes effect from the clock edge that captures the write. In the cycle of the write itself, `sum_out` still reflects the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low asynchronous reset, clears all masks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Macrocell index in [6:3], slice index in [2:0] |
| cfg_wdata | input | 16 | Slice of routing enables, one bit per term |
| pt_in | input | 80 | Product term vector |
| sum_out | output | 16 | OR-sum per macrocell |
| err_count | output | 1 | Some macrocell holds more than 16 terms |
| err_share | output | 1 | Some term is shared across groups of four |

## Verification
A configuration write and a change of the term vector can land in the same cycle. When they do, the combinational sums must use the old mask until the capturing edge, and the new mask from that edge on. The bench provokes this by driving a new `pt_in` together with a write that routes that term to an empty macrocell. It samples the sum once before the edge, where the old mask must give 0, and once after it, where the new mask must give 1. Random rounds also mix writes and term patterns freely. Each sum and flag is judged against a shadow model of the masks that the bench keeps itself.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int PT_N    = 80;
  localparam int MC_N    = 16;
  localparam int GRP_SZ  = 4;
  localparam int PT_MAX  = 16;
  localparam int WD_W    = 16;
  localparam int N_WORDS = (PT_N + WD_W - 1) / WD_W;
  localparam int WSEL_W  = $clog2(N_WORDS);
  localparam int MC_W    = $clog2(MC_N);
  localparam int ADDR_W  = MC_W + WSEL_W;
  localparam int GRP_N   = MC_N / GRP_SZ;
  localparam int CNT_W   = $clog2(PT_N + 1);
  localparam int STORE_W = N_WORDS * WD_W;

  // number of enabled terms in one mask
  function automatic logic [CNT_W-1:0] pt_count(input logic [PT_N-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < PT_N; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  // more than one bit set
  function automatic logic multi_hot(input logic [GRP_N-1:0] v);
    return |(v & (v - 1'b1));
  endfunction
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store
  import pta_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WD_W-1:0]        wr_data,
  output logic [MC_N*PT_N-1:0]   mask_flat
);
  logic [STORE_W-1:0] mask_r [MC_N];
  logic [MC_W-1:0]    wr_mc;
  logic [WSEL_W-1:0]  wr_word;
  logic               wr_ok;

  assign wr_mc   = wr_addr[ADDR_W-1:WSEL_W];
  assign wr_word = wr_addr[WSEL_W-1:0];
  assign wr_ok   = wr_en && ({1'b0, wr_word} < (WSEL_W+1)'(N_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < MC_N; m++) mask_r[m] <= '0;
    end else if (wr_ok) begin
      mask_r[wr_mc][wr_word*WD_W +: WD_W] <= wr_data;
    end
  end

  for (genvar m = 0; m < MC_N; m++) begin : g_out
    assign mask_flat[m*PT_N +: PT_N] = mask_r[m][PT_N-1:0];
  end
endmodule

// File: rtl/pta_sum_plane.sv
module pta_sum_plane
  import pta_pkg::*;
(
  input  logic [PT_N-1:0]        terms,
  input  logic [MC_N*PT_N-1:0]   mask_flat,
  output logic [MC_N-1:0]        sums,
  output logic [MC_N-1:0]        zero_mc
);
  for (genvar m = 0; m < MC_N; m++) begin : g_mc
    logic [PT_N-1:0] sel;
    assign sel        = mask_flat[m*PT_N +: PT_N];
    assign sums[m]    = |(terms & sel);
    assign zero_mc[m] = ~|sel;
  end
endmodule

// File: rtl/pta_rule_check.sv
module pta_rule_check
  import pta_pkg::*;
(
  input  logic [MC_N*PT_N-1:0]   mask_flat,
  output logic [MC_N-1:0]        over_mc,
  output logic [PT_N-1:0]        spread_pt,
  output logic                   err_count,
  output logic                   err_share
);
  for (genvar m = 0; m < MC_N; m++) begin : g_cnt
    assign over_mc[m] = pt_count(mask_flat[m*PT_N +: PT_N]) > CNT_W'(PT_MAX);
  end

  for (genvar t = 0; t < PT_N; t++) begin : g_pt
    logic [GRP_N-1:0] grp_use;
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      logic [GRP_SZ-1:0] col;
      for (genvar k = 0; k < GRP_SZ; k++) begin : g_k
        assign col[k] = mask_flat[(g*GRP_SZ + k)*PT_N + t];
      end
      assign grp_use[g] = |col;
    end
    assign spread_pt[t] = multi_hot(grp_use);
  end

  assign err_count = |over_mc;
  assign err_share = |spread_pt;
endmodule

// File: rtl/pta_top.sv
module pta_top
  import pta_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [WD_W-1:0]      cfg_wdata,
  input  logic [PT_N-1:0]      pt_in,
  output logic [MC_N-1:0]      sum_out,
  output logic                 err_count,
  output logic                 err_share
);
  logic [MC_N*PT_N-1:0] mask_flat;
  logic [MC_N-1:0]      zero_mc;
  logic [MC_N-1:0]      over_mc;
  logic [PT_N-1:0]      spread_pt;

  pta_cfg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_wdata),
    .mask_flat (mask_flat)
  );

  pta_sum_plane u_plane (
    .terms     (pt_in),
    .mask_flat (mask_flat),
    .sums      (sum_out),
    .zero_mc   (zero_mc)
  );

  pta_rule_check u_rules (
    .mask_flat (mask_flat),
    .over_mc   (over_mc),
    .spread_pt (spread_pt),
    .err_count (err_count),
    .err_share (err_share)
  );
endmodule

// File: rtl/pta_checker.sv
module pta_checker
  import pta_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [WD_W-1:0]      cfg_wdata,
  input logic [MC_N*PT_N-1:0] mask_flat,
  input logic [MC_N-1:0]      zero_mc,
  input logic [MC_N-1:0]      sum_out,
  input logic                 err_count,
  input logic                 err_share
);
  logic [MC_N-1:0] too_many;
  logic            any_spread;
  logic            bad_word;
  logic            good_wr;
  int              wr_pos;

  for (genvar m = 0; m < MC_N; m++) begin : g_tm
    assign too_many[m] = $countones(mask_flat[m*PT_N +: PT_N]) > PT_MAX;
  end

  always_comb begin
    any_spread = 1'b0;
    for (int t = 0; t < PT_N; t++) begin
      logic [GRP_N-1:0] hit;
      hit = '0;
      for (int m = 0; m < MC_N; m++)
        if (mask_flat[m*PT_N + t]) hit[m / GRP_SZ] = 1'b1;
      if ($countones(hit) > 1) any_spread = 1'b1;
    end
  end

  assign bad_word = cfg_we && (int'(cfg_addr[WSEL_W-1:0]) >= N_WORDS);
  assign good_wr  = cfg_we && !bad_word;
  assign wr_pos   = int'(cfg_addr[ADDR_W-1:WSEL_W]) * PT_N
                  + int'(cfg_addr[WSEL_W-1:0]) * WD_W;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> mask_flat[$past(wr_pos) +: WD_W] == $past(cfg_wdata)) else $error("R2"); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mask_flat)) else $error("R8"); // R8

  AST_BAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |=> $stable(mask_flat)) else $error("R7"); // R7

  AST_COUNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == (|too_many)) else $error("R5"); // R5

  AST_SHARE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_share == any_spread) else $error("R6"); // R6

  for (genvar m = 0; m < MC_N; m++) begin : g_zero
    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      zero_mc[m] |-> !sum_out[m]) else $error("R4"); // R4
  end
endmodule

bind pta_top pta_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .mask_flat (mask_flat),
  .zero_mc   (zero_mc),
  .sum_out   (sum_out),
  .err_count (err_count),
  .err_share (err_share)
);

// File: tb/pta_top_bench.sv
module pta_top_bench;
  import pta_pkg::*;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_we = 1'b0;
  logic [ADDR_W-1:0]   cfg_addr = '0;
  logic [WD_W-1:0]     cfg_wdata = '0;
  logic [PT_N-1:0]     pt_in = '0;
  logic [MC_N-1:0]     sum_out;
  logic                err_count, err_share;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [PT_N-1:0] mdl [MC_N];

  always #5 clk = ~clk;

  pta_top u_pta_top (.*);

  function automatic logic [MC_N-1:0] exp_sum(input logic [PT_N-1:0] p);
    logic [MC_N-1:0] s = '0;
    for (int m = 0; m < MC_N; m++)
      for (int t = 0; t < PT_N; t++)
        if (mdl[m][t] && p[t]) s[m] = 1'b1;
    return s;
  endfunction

  function automatic logic exp_cnt_err();
    for (int m = 0; m < MC_N; m++) begin
      int c = 0;
      for (int t = 0; t < PT_N; t++) c += int'(mdl[m][t]);
      if (c > PT_MAX) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic exp_share_err();
    for (int t = 0; t < PT_N; t++) begin
      int first = -1;
      for (int m = 0; m < MC_N; m++)
        if (mdl[m][t]) begin
          if (first < 0) first = m / GRP_SZ;
          else if (first != m / GRP_SZ) return 1'b1;
        end
    end
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [MC_N-1:0] act, input logic [MC_N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " sum"}, sum_out, exp_sum(pt_in));
    chk({req, " count flag"}, {15'b0, err_count}, {15'b0, exp_cnt_err()});
    chk({req, " share flag"}, {15'b0, err_share}, {15'b0, exp_share_err()});
  endtask

  task automatic wr(input int mc, input int word, input logic [WD_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {MC_W'(mc), WSEL_W'(word)};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (word < N_WORDS) mdl[mc][word*WD_W +: WD_W] = d;
    #1;
  endtask

  task automatic clear_all();
    for (int m = 0; m < MC_N; m++)
      for (int w = 0; w < N_WORDS; w++) wr(m, w, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    for (int m = 0; m < MC_N; m++) mdl[m] = '0;
    pt_in = '1;
    #23;
    chk("R1 in reset", sum_out, '0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_all("R1 after reset");

    // R5 exactly 16 terms, then 17
    wr(0, 0, 16'hFFFF);
    pt_in = '0; pt_in[7] = 1'b1; #1;
    chk_all("R3 R5 sixteen terms");
    chk("R5 no flag at 16", {15'b0, err_count}, '0);
    wr(0, 1, 16'h0001);
    chk("R5 flag at 17", {15'b0, err_count}, 16'h0001);
    clear_all();

    // R4 empty macrocell
    wr(2, 3, 16'h00F0);
    pt_in = '1; #1;
    chk("R4 empty mc", {15'b0, sum_out[3]}, '0);
    chk_all("R4 R3 all ones");

    // R6 sharing in group, then across
    for (int m = 4; m < 8; m++) wr(m, 0, 16'h0020);
    pt_in = '0; pt_in[5] = 1'b1; #1;
    chk_all("R6 in-group share");
    chk("R6 no flag", {15'b0, err_share}, '0);
    wr(8, 0, 16'h0020); #1;
    chk("R6 cross-group flag", {15'b0, err_share}, 16'h0001);
    chk_all("R6 cross-group sums");

    // R7 slice index 5..7 ignored
    wr(1, 5, 16'hFFFF);
    wr(1, 7, 16'hFFFF);
    pt_in = '1; #1;
    chk("R7 mc1 untouched", {15'b0, sum_out[1]}, '0);
    chk_all("R7 flags and sums");
    clear_all();

    // R8 write and term change in the same cycle
    @(negedge clk);
    pt_in = '0; pt_in[40] = 1'b1;
    cfg_we = 1'b1; cfg_addr = {MC_W'(9), WSEL_W'(2)}; cfg_wdata = 16'h0100;
    #1;
    chk("R8 old mask before edge", {15'b0, sum_out[9]}, '0);
    @(negedge clk);
    cfg_we = 1'b0; mdl[9][40] = 1'b1; #1;
    chk("R8 new mask after edge", {15'b0, sum_out[9]}, 16'h0001);
    chk_all("R8 R2 full");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int mc = int'($urandom_range(MC_N-1));
      int wd = int'($urandom_range(7));
      logic [WD_W-1:0] d = WD_W'($urandom & $urandom & $urandom);
      wr(mc, wd, d);
      for (int k = 0; k < 4; k++) begin
        pt_in = {$urandom, $urandom, $urandom} ;
        #1;
        chk_all("R2 R3 R5 R6 random");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule